// File: doc/BRIEF.md
# Radix Page Tree Walker

This block turns a 64-bit effective address into the leaf entry of a multi-level radix page tree held in memory. The tree is found through a process table. The walker takes the effective page number, a process identifier and the process-table base and size fields. It first reads the root entry for the process and checks that the address lies in a legal segment. It then reads one directory entry per level until it meets a leaf or a fault.

Each level's index width comes from a size field in the entry fetched before it. A running shift records how many address bits remain below the current level. Memory is reached through a plain read port that has at most one read outstanding. When the walk ends, a one-cycle completion pulse carries one of two results. On success it gives the leaf entry and the final shift. On failure it gives a one-hot fault code.

Top module: `rw_walker`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `done` is 0, `mem_rd` is 0 and `fault` is 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. A `req_valid` seen while a walk is in progress has no effect on that walk's result. A new request may be taken in the same cycle that `done` is high.
- R3: The first read goes to the process-table entry address. It is built from 8 zero bits, then `req_ptb[43:24]`. Next come 24 bits that take `req_ptb[23:0]` where the low-`req_pts` mask is clear and the effective PID bits 31..8 where it is set. Then come the effective PID bits 7..0 and 4 zero bits. The effective PID is 0 when address bit 63 is 1, and `req_pid` otherwise.
- R4: The segment check uses the tree size as a mask of that many low ones. Address bits 63 and 62 must match. Address bits 61..31 must be zero wherever this mask is clear. Otherwise the walk ends with fault `3'b001`, and no directory is read.
- R5: The root entry is decoded as follows. The tree size is {bits 7:5, bits 62:61}. The root directory size is bits 4:0. The root base is bits 55:8 with the low 8 address bits zero. The walk ends with fault `3'b010` if the directory size is below 5, above 16, or above tree size + 19. Otherwise the shift becomes tree size + 19 − directory size.
- R6: A directory entry address is formed in four parts. It starts with 8 zero bits, then base bits 55..19. Next come 16 bits that take base bits 18..3 where the low-size mask is clear and the shifted page number (address bits 59..12 shifted right by the shift) where it is set. It ends with 3 zero bits.
- R7: A directory entry with bit 63 (valid) clear ends the walk with fault `3'b100`, and no further read is made.
- R8: A valid entry with bit 62 (leaf) set ends the walk with fault 0. It returns the entry on `leaf_pte` and the current shift on `final_shift`.
- R9: A valid non-leaf entry gives the next base (bits 55:8) and the next size (bits 4:0). The walk ends with fault `3'b010` if that size is below 5, above 16, or larger than the remaining shift. Otherwise the shift is reduced by the size.
- R10: A non-leaf entry found at directory level `MAX_LEVELS` ends the walk with fault `3'b010`.
- R11: `done` is high for exactly one cycle per walk. `fault` is one-hot or zero, and `leaf_pte` is zero whenever `fault` is nonzero.
- R12: `mem_rd` stays high with a stable `mem_addr` until `mem_ack`, and every read address is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_epn | input | 52 | Effective address bits 63..12 |
| req_pid | input | 32 | Process identifier register |
| req_ptb | input | 44 | Process table base, address bits 55..12 |
| req_pts | input | 5 | Process table size field (index mask width) |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_rd | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 64 | Read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | 001 segment, 010 bad tree, 100 no entry |
| leaf_pte | output | 64 | Leaf entry on success, zero on fault |
| final_shift | output | 6 | Remaining shift at the leaf |

## Verification
The completion pulse and the acceptance of the next request can land in the same cycle, because the walker returns to idle as it raises `done`. The bench provokes this by raising `req_valid` with a segment-faulting address in the very cycle it first sees `done`. It then requires `done` to be low one cycle later and the second walk to report the segment fault. A second overlap is a request strobe arriving in the middle of a walk. This is judged by requiring the first walk's leaf to come back unchanged.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int EPN_W   = 52;
  localparam int PID_W   = 32;
  localparam int PTB_W   = 44;
  localparam int SZ_W    = 5;
  localparam int SH_W    = 6;
  localparam int ENT_W   = 64;
  localparam int BASE_W  = 48;
  localparam int FLT_W   = 3;
  localparam int MIN_SZ  = 5;
  localparam int MAX_SZ  = 16;
  localparam int SEG_OFS = 19;

  // entry bit positions
  localparam int E_VALID = 63;
  localparam int E_LEAF  = 62;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRT  = 2'd1,
    ST_SEG  = 2'd2,
    ST_DIR  = 2'd3
  } walk_st_t;

  localparam logic [FLT_W-1:0] FLT_NONE = 3'b000;
  localparam logic [FLT_W-1:0] FLT_SEG  = 3'b001;
  localparam logic [FLT_W-1:0] FLT_BAD  = 3'b010;
  localparam logic [FLT_W-1:0] FLT_NOPT = 3'b100;
endpackage

// File: rtl/rw_rst_sync.sv
module rw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/rw_prt_addr.sv
module rw_prt_addr
  import rw_pkg::*;
(
  input  logic             pid_zero,
  input  logic [PID_W-1:0] pid,
  input  logic [PTB_W-1:0] ptb,
  input  logic [SZ_W-1:0]  pts,
  output logic [63:0]      prt_addr
);
  localparam int MW = 24;

  logic [MW-1:0]    msk;
  logic [PID_W-1:0] eff_pid;

  always_comb begin
    for (int i = 0; i < MW; i++) msk[i] = (SZ_W'(i) < pts);
  end

  assign eff_pid  = pid_zero ? '0 : pid;
  assign prt_addr = {8'h00, ptb[PTB_W-1:MW],
                     (ptb[MW-1:0] & ~msk) | (eff_pid[31:8] & msk),
                     eff_pid[7:0], 4'h0};
endmodule

// File: rtl/rw_seg_check.sv
module rw_seg_check
  import rw_pkg::*;
(
  input  logic [32:0]     hi_bits,   // address bits 63..31
  input  logic [SH_W-1:0] tree_sz,
  input  logic [SZ_W-1:0] dir_sz,
  output logic            seg_err,
  output logic            bad_root,
  output logic [SH_W-1:0] new_shift
);
  logic [30:0]     msk;
  logic [SH_W-1:0] limit;

  always_comb begin
    for (int i = 0; i < 31; i++) msk[i] = (SH_W'(i) < tree_sz);
  end

  assign limit     = tree_sz + SH_W'(SEG_OFS);
  assign seg_err   = (hi_bits[32] != hi_bits[31]) | (|(hi_bits[30:0] & ~msk));
  assign bad_root  = (dir_sz < SZ_W'(MIN_SZ)) | (dir_sz > SZ_W'(MAX_SZ)) |
                     ({1'b0, dir_sz} > limit);
  assign new_shift = limit - {1'b0, dir_sz};
endmodule

// File: rtl/rw_pde_addr.sv
module rw_pde_addr
  import rw_pkg::*;
(
  input  logic [BASE_W-1:0] base,   // base bits 55..8
  input  logic [47:0]       vpn,    // address bits 59..12
  input  logic [SH_W-1:0]   shift,
  input  logic [SZ_W-1:0]   size,
  output logic [63:0]       pde_addr
);
  localparam int IW = 16;

  logic [IW-1:0] msk;
  logic [IW-1:0] idx;
  logic [IW-1:0] fld;

  always_comb begin
    for (int i = 0; i < IW; i++) msk[i] = (SZ_W'(i) < size);
  end

  assign idx      = IW'(vpn >> shift);
  assign fld      = {base[10:0], 5'b00000};
  assign pde_addr = {8'h00, base[BASE_W-1:11], (fld & ~msk) | (idx & msk), 3'b000};
endmodule

// File: rtl/rw_walker.sv
module rw_walker
  import rw_pkg::*;
#(
  parameter int MAX_LEVELS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [EPN_W-1:0] req_epn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [PTB_W-1:0] req_ptb,
  input  logic [SZ_W-1:0]  req_pts,
  output logic             req_ready,
  output logic             mem_rd,
  output logic [63:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             done,
  output logic [FLT_W-1:0] fault,
  output logic [ENT_W-1:0] leaf_pte,
  output logic [SH_W-1:0]  final_shift
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  logic rst_i_n;
  rw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  walk_st_t          st_q, st_d;
  logic [EPN_W-1:0]  epn_q;
  logic [PID_W-1:0]  pid_q;
  logic [PTB_W-1:0]  ptb_q;
  logic [SZ_W-1:0]   pts_q;
  logic [SH_W-1:0]   shift_q, shift_d;
  logic [SZ_W-1:0]   size_q, size_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              done_q, done_d;
  logic [FLT_W-1:0]  fault_q, fault_d;
  logic [ENT_W-1:0]  pte_q, pte_d;

  logic              take_req;
  logic [63:0]       prt_addr, pde_addr;
  logic              seg_err, bad_root;
  logic [SH_W-1:0]   seg_shift;
  logic [SZ_W-1:0]   ent_size;
  logic [SZ_W-1:0]   root_tree;
  logic              bad_next, lvl_full;

  assign take_req  = req_valid & (st_q == ST_IDLE);
  assign ent_size  = mem_rdata[SZ_W-1:0];
  assign root_tree = {mem_rdata[7:5], mem_rdata[62:61]};
  assign bad_next  = (ent_size < SZ_W'(MIN_SZ)) | (ent_size > SZ_W'(MAX_SZ)) |
                     ({1'b0, ent_size} > shift_q);
  assign lvl_full  = (lvl_q == LVL_W'(MAX_LEVELS));

  rw_prt_addr u_prt (
    .pid_zero(epn_q[EPN_W-1]), .pid(pid_q), .ptb(ptb_q), .pts(pts_q),
    .prt_addr(prt_addr)
  );

  rw_seg_check u_seg (
    .hi_bits(epn_q[EPN_W-1:EPN_W-33]), .tree_sz(shift_q), .dir_sz(size_q),
    .seg_err(seg_err), .bad_root(bad_root), .new_shift(seg_shift)
  );

  rw_pde_addr u_pde (
    .base(base_q), .vpn(epn_q[47:0]), .shift(shift_q), .size(size_q),
    .pde_addr(pde_addr)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    shift_d = shift_q;
    size_d  = size_q;
    base_d  = base_q;
    lvl_d   = lvl_q;
    done_d  = 1'b0;
    fault_d = fault_q;
    pte_d   = pte_q;
    unique case (st_q)
      ST_IDLE: if (take_req) st_d = ST_PRT;
      ST_PRT: if (mem_ack) begin
        shift_d = {1'b0, root_tree};
        size_d  = ent_size;
        base_d  = mem_rdata[55:8];
        st_d    = ST_SEG;
      end
      ST_SEG: begin
        if (seg_err || bad_root) begin
          done_d  = 1'b1;
          fault_d = seg_err ? FLT_SEG : FLT_BAD;
          pte_d   = '0;
          st_d    = ST_IDLE;
        end else begin
          shift_d = seg_shift;
          lvl_d   = LVL_W'(1);
          st_d    = ST_DIR;
        end
      end
      ST_DIR: if (mem_ack) begin
        if (!mem_rdata[E_VALID]) begin
          done_d  = 1'b1;
          fault_d = FLT_NOPT;
          pte_d   = '0;
          st_d    = ST_IDLE;
        end else if (mem_rdata[E_LEAF]) begin
          done_d  = 1'b1;
          fault_d = FLT_NONE;
          pte_d   = mem_rdata;
          st_d    = ST_IDLE;
        end else if (bad_next || lvl_full) begin
          done_d  = 1'b1;
          fault_d = FLT_BAD;
          pte_d   = '0;
          st_d    = ST_IDLE;
        end else begin
          shift_d = shift_q - {1'b0, ent_size};
          size_d  = ent_size;
          base_d  = mem_rdata[55:8];
          lvl_d   = lvl_q + LVL_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      epn_q <= '0;
      pid_q <= '0;
      ptb_q <= '0;
      pts_q <= '0;
    end else if (take_req) begin
      epn_q <= req_epn;
      pid_q <= req_pid;
      ptb_q <= req_ptb;
      pts_q <= req_pts;
    end
  end

  // walk state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      shift_q <= '0;
      size_q  <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      pte_q   <= '0;
    end else begin
      st_q    <= st_d;
      shift_q <= shift_d;
      size_q  <= size_d;
      base_q  <= base_d;
      lvl_q   <= lvl_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      pte_q   <= pte_d;
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign mem_rd      = (st_q == ST_PRT) | (st_q == ST_DIR);
  assign mem_addr    = (st_q == ST_PRT) ? prt_addr : pde_addr;
  assign done        = done_q;
  assign fault       = fault_q;
  assign leaf_pte    = pte_q;
  assign final_shift = shift_q;
endmodule

// File: rtl/rw_walker_chk.sv
module rw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_rd,
  input logic [63:0] mem_addr,
  input logic        mem_ack,
  input logic        done,
  input logic [2:0]  fault,
  input logic [63:0] leaf_pte
);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(fault));

  a_r11_pte_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 3'b000) |-> (leaf_pte == 64'd0));

  a_r8_leaf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 3'b000) |-> (leaf_pte[63] && leaf_pte[62]));

  a_r12_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

  a_r12_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[2:0] == 3'b000));

  a_r2_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd);
endmodule

bind rw_walker rw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done), .fault(fault),
  .leaf_pte(leaf_pte)
);

// File: tb/rw_walker_test.sv
module rw_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] LEAF_A = 64'hC000_0000_1234_5007;
  localparam logic [63:0] LEAF_B = 64'hC000_0000_0ABC_D003;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] pid;
    logic [43:0] ptb;
    logic [4:0]  pts;
    logic [2:0]  flt;
    logic [63:0] pte;
    logic [5:0]  sh;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_1000, 32'h0,   44'h10, 5'd0, 3'b000, LEAF_A, 6'd9},  // R8 two levels
    '{64'h0000_0000_0020_1000, 32'h0,   44'h10, 5'd0, 3'b100, 64'h0,  6'd0},  // R7 missing entry
    '{64'h4000_0000_0000_1000, 32'h0,   44'h10, 5'd0, 3'b001, 64'h0,  6'd0},  // R4 bits 63/62 differ
    '{64'h0000_0800_0000_1000, 32'h0,   44'h10, 5'd0, 3'b001, 64'h0,  6'd0},  // R4 bit 43 outside
    '{64'h0000_0400_0000_1000, 32'h0,   44'h10, 5'd0, 3'b000, LEAF_B, 6'd18}, // R6 bit 42 indexes
    '{64'hC000_0000_0000_1000, 32'h5,   44'h10, 5'd0, 3'b000, LEAF_A, 6'd9},  // R3 pid forced
    '{64'h0000_0000_0000_1000, 32'h1,   44'h10, 5'd0, 3'b010, 64'h0,  6'd0},  // R5 size 4
    '{64'h0000_0000_0000_1000, 32'h2,   44'h10, 5'd0, 3'b010, 64'h0,  6'd0},  // R5 size 17
    '{64'h0000_0000_0000_1000, 32'h3,   44'h10, 5'd0, 3'b010, 64'h0,  6'd0},  // R9 next size 4
    '{64'h0000_0000_0000_1000, 32'h4,   44'h10, 5'd0, 3'b010, 64'h0,  6'd0},  // R10 depth
    '{64'h0000_0000_0000_1000, 32'h5,   44'h10, 5'd0, 3'b010, 64'h0,  6'd0},  // R9 shift negative
    '{64'h0000_0000_0000_1000, 32'h100, 44'h10, 5'd4, 3'b000, LEAF_A, 6'd9}   // R3 pid in base
  };

  localparam int NM = 16;
  localparam logic [63:0] MA [NM] = '{
    64'h10000, 64'h10010, 64'h10020, 64'h10030, 64'h10040, 64'h10050, 64'h11000,
    64'h20000, 64'h28000, 64'h30000, 64'h40000, 64'h50000, 64'h60000, 64'h70000,
    64'h80000, 64'hA0000};
  localparam logic [63:0] MD [NM] = '{
    64'h0000_0000_0002_006D, 64'h0000_0000_0002_0064, 64'h0000_0000_0002_0071,
    64'h0000_0000_0004_0065, 64'h6000_0000_0005_00E5, 64'h0000_0000_000A_0005,
    64'h0000_0000_0002_006D, 64'h8000_0000_0003_0009, LEAF_B, LEAF_A,
    64'h8000_0000_0000_0004, 64'h8000_0000_0006_0009, 64'h8000_0000_0007_0009,
    64'h8000_0000_0008_0009, 64'h8000_0000_0009_0009, 64'h8000_0000_000B_000F};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [51:0] req_epn;
  logic [31:0] req_pid;
  logic [43:0] req_ptb;
  logic [4:0]  req_pts;
  logic        req_ready;
  logic        mem_rd;
  logic [63:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic [2:0]  fault;
  logic [63:0] leaf_pte;
  logic [5:0]  final_shift;

  int checks = 0;
  int errors = 0;
  int stall = 0;
  int wcnt = 0;
  int rd_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rw_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_epn(req_epn),
    .req_pid(req_pid), .req_ptb(req_ptb), .req_pts(req_pts),
    .req_ready(req_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .leaf_pte(leaf_pte), .final_shift(final_shift)
  );

  function automatic logic [63:0] mem_lookup(input logic [63:0] a);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < NM; i++) if (MA[i] == a) r = MD[i];
    return r;
  endfunction

  function automatic string vreq(input int i);
    case (i)
      0: return "R8";
      1: return "R7";
      2, 3: return "R4";
      4: return "R6";
      5, 11: return "R3";
      6, 7: return "R5";
      9: return "R10";
      default: return "R9";
    endcase
  endfunction

  // memory model: one read outstanding, optional stall cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_rd) begin
      if (wcnt < stall) wcnt <= wcnt + 1;
      else begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_lookup(mem_addr);
        wcnt      <= 0;
      end
    end
    if (rst_n && wcnt != 0 && !mem_rd) rd_drop <= rd_drop + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_epn = v.addr[63:12];
    req_pid = v.pid;
    req_ptb = v.ptb;
    req_pts = v.pts;
  endtask

  task automatic start_req(input vec_t v);
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (n >= 400) chk("R11 done timeout", 64'd0, 64'd1);
  endtask

  task automatic check_result(input string tag, input vec_t v);
    chk({tag, " fault"}, 64'(fault), 64'(v.flt));
    chk({tag, " leaf_pte"}, leaf_pte, v.pte);
    if (v.flt == 3'b000) chk({tag, " final_shift"}, 64'(final_shift), 64'(v.sh));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(req_ready), 64'd1);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 mem_rd in reset", 64'(mem_rd), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 fault after reset", 64'(fault), 64'd0);

    // table of walks
    for (int i = 0; i < NV; i++) begin
      start_req(VECS[i]);
      wait_done();
      check_result($sformatf("%s vector %0d", vreq(i), i), VECS[i]);
    end

    // R2: strobe during a walk is ignored
    start_req(VECS[0]);
    for (int k = 0; k < 2; k++) begin
      chk("R2 busy not ready", 64'(req_ready), 64'd0);
      drive(VECS[2]);
      req_valid = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done();
    check_result("R2 busy strobe ignored", VECS[0]);

    // R2/R11: new request taken in the done cycle
    chk("R2 ready with done", 64'(req_ready), 64'd1);
    drive(VECS[3]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 done one cycle", 64'(done), 64'd0);
    wait_done();
    check_result("R2 back-to-back", VECS[3]);

    // R12: stalled memory
    stall = 3;
    start_req(VECS[4]);
    wait_done();
    check_result("R12 stalled reads", VECS[4]);
    chk("R12 read held", 64'(rd_drop), 64'd0);
    stall = 0;

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule